// File: doc/BRIEF.md
# Deflection Router Local Access Stage

This block is the local access stage of a bufferless deflection router. It sits in front of the permutation network. Each cycle it looks at the four flits arriving on the router's input slots. It removes at most one flit addressed to this node and hands that flit to the reassembly logic. It then places at most one new flit from the node's injection FIFO into an input slot that is empty. The result goes out registered on four output slots.

The block applies the livelock-freedom priority at the ejection point. A flit that belongs to the packet currently marked as golden is ejected before any other local flit. Other local flits that lose ejection stay in the network and are later deflected by the routing stage. New traffic only fills a slot that is already empty, or one just vacated by ejection. It never displaces a flit already in flight, so injected traffic always has the lowest priority. Routing decisions and reassembly storage live outside this block.

Top module: `ijs_top`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it, every output slot is all zero and eject_valid_o is 0.
- R2: A slot holds a flit when its top bit (valid) is 1. Slot p occupies bits [p*35 +: 35], with fields from MSB down: valid(1), dest(6), src(6), req(3), seq(3), data(16). A flit is local when valid is 1 and dest equals node_id_i. When at least one local flit is present, exactly one is ejected. One cycle later it appears on eject_flit_o with eject_valid_o high, and its slot is all zero on the output unless an injection refills it.
- R3: A local flit whose {src,req} equals golden_id_i is ejected ahead of every local flit that is not golden. A golden flit that is not local is never ejected.
- R4: Among candidates of equal class, the slot with the lowest index wins (slot 0 = N, 1 = E, 2 = S, 3 = W).
- R5: Every valid flit that is not ejected appears unchanged on the same output slot one cycle later.
- R6: When fifo_empty_i is 0 and some slot is free (invalid, or ejected this cycle), fifo_data_i with valid set to 1 is placed into the lowest-index free slot one cycle later.
- R7: fifo_pop_o is high in exactly the cycles in which an injection occurs. With four valid non-local flits it stays low and nothing changes.
- R8: With fifo_empty_i high, fifo_pop_o is low and empty slots leave the stage all zero.
- R9: A slot whose valid bit is 0 is never ejected and never copied through, whatever its other bits hold.
- R10: At most one flit is injected per cycle, even when several slots are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | 6 | ID of the local node |
| golden_id_i | input | 9 | Golden packet identifier {src,req} |
| in_flits_i | input | 140 | Four incoming flit slots |
| fifo_empty_i | input | 1 | Injection FIFO is empty |
| fifo_data_i | input | 34 | Head flit of the injection FIFO, without the valid bit |
| fifo_pop_o | output | 1 | Pops the injection FIFO this cycle |
| eject_valid_o | output | 1 | eject_flit_o holds an ejected flit |
| eject_flit_o | output | 35 | Ejected flit |
| out_flits_o | output | 140 | Four outgoing flit slots |

## Verification
The hardest case to set up is one where ejection priority and injection placement interact in the same cycle. One example is a golden local flit that sits behind lower-index non-golden local flits. Another is a freed slot that must win injection over a higher-index slot that was already empty. Directed vectors reach these cases by placing local and foreign flits in chosen slot patterns. They switch the golden identifier between the competing packets and toggle FIFO emptiness. Each case checks the combinational pop before the clock edge and the registered slots and ejection port after it.

// File: rtl/ijs_pkg.sv
package ijs_pkg;
  parameter int NODE_W = 6;
  parameter int REQ_W  = 3;
  parameter int SEQ_W  = 3;
  parameter int DATA_W = 16;
  localparam int PKT_W  = NODE_W + REQ_W;

  typedef struct packed {
    logic              valid;
    logic [NODE_W-1:0] dest;
    logic [NODE_W-1:0] src;
    logic [REQ_W-1:0]  req;
    logic [SEQ_W-1:0]  seq;
    logic [DATA_W-1:0] data;
  } flit_t;

  localparam int FLIT_W = $bits(flit_t);
endpackage

// File: rtl/ijs_eject_pick.sv
module ijs_eject_pick
  import ijs_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NODE_W-1:0]     node_id_i,
  input  logic [PKT_W-1:0]      golden_id_i,
  input  flit_t                 flits_i [NUM_PORTS],
  output logic [NUM_PORTS-1:0]  gnt_o
);
  logic [NUM_PORTS-1:0] local_v, gold_v;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_cls
    assign local_v[p] = flits_i[p].valid && (flits_i[p].dest == node_id_i);
    assign gold_v[p]  = local_v[p] && ({flits_i[p].src, flits_i[p].req} == golden_id_i);
  end

  // golden class first, lowest slot within a class
  always_comb begin
    logic [NUM_PORTS-1:0] cand;
    logic                 found;
    cand  = (|gold_v) ? gold_v : local_v;
    gnt_o = '0;
    found = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (cand[p] && !found) begin
        gnt_o[p] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  AST_EJECT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R2
  AST_EJECT_WHEN_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|local_v) |-> (|gnt_o)); // R2
  AST_GOLDEN_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gold_v) |-> (|(gnt_o & gold_v))); // R3
  AST_EJECT_ONLY_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~local_v) == '0); // R9
endmodule

// File: rtl/ijs_inject_pick.sv
module ijs_inject_pick #(
  parameter int NUM_PORTS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PORTS-1:0]  busy_i,
  input  logic [NUM_PORTS-1:0]  eject_gnt_i,
  input  logic                  fifo_empty_i,
  output logic [NUM_PORTS-1:0]  gnt_o,
  output logic                  pop_o
);
  logic [NUM_PORTS-1:0] free_v;
  assign free_v = ~busy_i | eject_gnt_i;

  always_comb begin
    logic found;
    gnt_o = '0;
    found = fifo_empty_i;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (free_v[p] && !found) begin
        gnt_o[p] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign pop_o = |gnt_o;

  AST_INJECT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R10
  AST_POP_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> !fifo_empty_i); // R8
  AST_NO_DISPLACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & busy_i & ~eject_gnt_i) == '0); // R7
endmodule

// File: rtl/ijs_top.sv
module ijs_top
  import ijs_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NODE_W-1:0]           node_id_i,
  input  logic [PKT_W-1:0]            golden_id_i,
  input  logic [NUM_PORTS*FLIT_W-1:0] in_flits_i,
  input  logic                        fifo_empty_i,
  input  logic [FLIT_W-2:0]           fifo_data_i,
  output logic                        fifo_pop_o,
  output logic                        eject_valid_o,
  output logic [FLIT_W-1:0]           eject_flit_o,
  output logic [NUM_PORTS*FLIT_W-1:0] out_flits_o
);
  flit_t                in_f  [NUM_PORTS];
  flit_t                nxt_f [NUM_PORTS];
  flit_t                out_q [NUM_PORTS];
  flit_t                ej_d, ej_q;
  logic [NUM_PORTS-1:0] busy, ej_gnt, inj_gnt, out_valid;
  logic                 ej_any;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_unpack
    assign in_f[p]                       = flit_t'(in_flits_i[p*FLIT_W +: FLIT_W]);
    assign busy[p]                       = in_f[p].valid;
    assign out_flits_o[p*FLIT_W +: FLIT_W] = out_q[p];
    assign out_valid[p]                  = out_q[p].valid;
  end

  ijs_eject_pick #(.NUM_PORTS(NUM_PORTS)) u_eject (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .node_id_i   (node_id_i),
    .golden_id_i (golden_id_i),
    .flits_i     (in_f),
    .gnt_o       (ej_gnt)
  );

  ijs_inject_pick #(.NUM_PORTS(NUM_PORTS)) u_inject (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_i       (busy),
    .eject_gnt_i  (ej_gnt),
    .fifo_empty_i (fifo_empty_i),
    .gnt_o        (inj_gnt),
    .pop_o        (fifo_pop_o)
  );

  assign ej_any = |ej_gnt;

  always_comb begin
    ej_d = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (ej_gnt[p]) ej_d = ej_d | in_f[p];
      if (inj_gnt[p])
        nxt_f[p] = flit_t'({1'b1, fifo_data_i});
      else if (busy[p] && !ej_gnt[p])
        nxt_f[p] = in_f[p];
      else
        nxt_f[p] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PORTS; p++) out_q[p] <= '0;
      ej_q          <= '0;
      eject_valid_o <= 1'b0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) out_q[p] <= nxt_f[p];
      ej_q          <= ej_d;
      eject_valid_o <= ej_any;
    end
  end

  assign eject_flit_o = ej_q;

  AST_FLIT_CONSERVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ($countones(out_valid) ==
      $countones($past(busy)) - $countones($past(ej_gnt)) + $countones($past(inj_gnt)))); // R5
  AST_EJECT_VALID_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eject_valid_o |-> ej_q.valid); // R2
endmodule

// File: tb/tb_ijs_top.sv
module tb_ijs_top;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 35;
  localparam logic [5:0] NODE = 6'd9;

  logic             clk_i = 0, rst_ni = 0;
  logic [5:0]       node_id_i = NODE;
  logic [8:0]       golden_id_i = '0;
  logic [4*FW-1:0]  in_flits_i = '0;
  logic             fifo_empty_i = 1'b1;
  logic [FW-2:0]    fifo_data_i = '0;
  logic             fifo_pop_o, eject_valid_o;
  logic [FW-1:0]    eject_flit_o;
  logic [4*FW-1:0]  out_flits_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ijs_top dut (.*);

  function automatic logic [FW-1:0] mk(logic v, logic [5:0] d, logic [5:0] s,
                                       logic [2:0] r, logic [2:0] q, logic [15:0] x);
    return {v, d, s, r, q, x};
  endfunction

  task automatic chk(string rq, string what, logic [4*FW-1:0] act, logic [4*FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // drive one cycle, check pop before the edge, registered outputs after
  task automatic step(logic [FW-1:0] s0, s1, s2, s3, logic fe, logic [FW-2:0] fd,
                      string rq, logic exp_pop, logic exp_ev, logic [FW-1:0] exp_ej,
                      logic [FW-1:0] e0, e1, e2, e3);
    @(negedge clk_i);
    in_flits_i   = {s3, s2, s1, s0};
    fifo_empty_i = fe;
    fifo_data_i  = fd;
    #1;
    chk(rq, "fifo_pop_o", fifo_pop_o, exp_pop);
    @(posedge clk_i); #1;
    chk(rq, "eject_valid_o", eject_valid_o, exp_ev);
    chk(rq, "eject_flit_o", eject_flit_o, exp_ej);
    chk(rq, "out_flits_o", out_flits_o, {e3, e2, e1, e0});
  endtask

  task automatic t_reset;
    chk("R1", "out during reset", out_flits_o, '0);
    chk("R1", "eject during reset", eject_valid_o, 0);
    @(negedge clk_i); rst_ni = 1;
    chk("R1", "out after reset", out_flits_o, '0);
    chk("R1", "eject_flit after reset", eject_flit_o, '0);
  endtask

  task automatic t_full_pass;
    logic [FW-1:0] a = mk(1, 6'd1, 6'd2, 3'd1, 0, 16'h1111);
    logic [FW-1:0] b = mk(1, 6'd3, 6'd4, 3'd2, 1, 16'h2222);
    logic [FW-1:0] c = mk(1, 6'd5, 6'd6, 3'd3, 2, 16'h3333);
    logic [FW-1:0] d = mk(1, 6'd7, 6'd8, 3'd4, 3, 16'h4444);
    step(a, b, c, d, 0, 34'h1_2345_6789, "R7_R5", 0, 0, '0, a, b, c, d);
  endtask

  task automatic t_eject_refill;
    logic [FW-1:0] a = mk(1, 6'd1, 6'd2, 3'd1, 0, 16'hA0A0);
    logic [FW-1:0] b = mk(1, 6'd3, 6'd4, 3'd2, 1, 16'hB0B0);
    logic [FW-1:0] l = mk(1, NODE, 6'd4, 3'd5, 2, 16'hC0C0);
    logic [FW-1:0] d = mk(1, 6'd7, 6'd8, 3'd4, 3, 16'hD0D0);
    logic [FW-2:0] nf = {6'd20, NODE, 3'd6, 3'd0, 16'hEEEE};
    step(a, b, l, d, 0, nf, "R2_R6", 1, 1, l, a, b, {1'b1, nf}, d);
  endtask

  task automatic t_golden;
    logic [FW-1:0] l0 = mk(1, NODE, 6'd1, 3'd1, 0, 16'h0101);
    logic [FW-1:0] l1 = mk(1, NODE, 6'd2, 3'd2, 0, 16'h0202);
    logic [FW-1:0] g3 = mk(1, NODE, 6'd3, 3'd3, 0, 16'h0303);
    golden_id_i = {6'd3, 3'd3};
    step(l0, l1, '0, g3, 1, '0, "R3_R8", 0, 1, g3, l0, l1, '0, '0);
  endtask

  task automatic t_golden_foreign;
    logic [FW-1:0] gf = mk(1, 6'd30, 6'd3, 3'd3, 0, 16'h0909);
    logic [FW-1:0] l2 = mk(1, NODE, 6'd5, 3'd1, 0, 16'h0A0A);
    golden_id_i = {6'd3, 3'd3};
    step(gf, '0, l2, '0, 1, '0, "R3", 0, 1, l2, gf, '0, '0, '0);
  endtask

  task automatic t_order;
    logic [FW-1:0] l1 = mk(1, NODE, 6'd2, 3'd1, 4, 16'h1A1A);
    logic [FW-1:0] l3 = mk(1, NODE, 6'd6, 3'd2, 5, 16'h3A3A);
    logic [FW-2:0] nf = {6'd11, NODE, 3'd1, 3'd1, 16'h5555};
    golden_id_i = {6'd63, 3'd7};
    step('0, l1, '0, l3, 0, nf, "R4_R6_R10", 1, 1, l1, {1'b1, nf}, '0, '0, l3);
  endtask

  task automatic t_invalid;
    logic [FW-1:0] ghost = mk(0, NODE, 6'd3, 3'd3, 1, 16'hDEAD);
    logic [FW-1:0] l1    = mk(1, NODE, 6'd4, 3'd4, 2, 16'hBEEF);
    golden_id_i = {6'd3, 3'd3};
    step(ghost, l1, '0, '0, 1, '0, "R9", 0, 1, l1, '0, '0, '0, '0);
  endtask

  task automatic t_idle;
    step('0, '0, '0, '0, 1, 34'h3_FFFF_FFFF, "R8", 0, 0, '0, '0, '0, '0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    t_reset();
    t_full_pass();
    t_eject_refill();
    t_golden();
    t_golden_foreign();
    t_order();
    t_invalid();
    t_idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule